// File: doc/BRIEF.md
# Audio Device Control Bank with Timed Reset Strobes

This block holds the byte-wide configuration words for two external audio devices: a digital audio receiver and an auxiliary converter. Each word is written and read through a simple synchronous port (address, write strobe, write data, combinational read data). The stored words drive the devices' configuration pins directly.

Each device also has an active-low reset line. The block pulls that line low for a fixed interval after its own reset is released. It pulls the line low for the same interval whenever a write changes one of the device's interface-format fields, because those fields must only change while the device is held in reset. The interval is given in microseconds and converted to clock cycles from a clock-frequency parameter. A reset-enable bit in each word also lets software hold its device in reset.

Top module: `audio_cfg_bank`

## Requirements
- R1: After reset, address 0 (receiver word) reads 0x38 and address 1 (converter word) reads 0x41.
- R2: Both reset outputs are low while the block is in reset and for exactly PULSE clock cycles after reset is released, where PULSE = CLK_HZ * PULSE_US / 1,000,000. After that they follow their reset-enable bits.
- R3: A write to address 0 that changes any of bits 3, 2 or 1 starts a receiver reset pulse. Bit 3 selects master or slave, bit 2 the clock ratio and bit 1 the data format.
- R4: A write to address 1 that changes bit 1 (the converter's data format) starts a converter reset pulse. It does not affect the receiver line.
- R5: A write that leaves the watched bits unchanged starts no pulse. This covers rewriting the same value and changing only other bits.
- R6: Each reset output equals its reset-enable bit AND NOT its pulse-active state. The enable bit is bit 4 of the receiver word and bit 0 of the converter word. A value of 0 holds the device in reset.
- R7: All 8 bits of both words can be written and read back. Addresses 2 and 3 read 0, and writes to them change nothing.
- R8: A watched-bit change during an active pulse restarts the full PULSE-cycle count from the cycle after that write.
- R9: A pulse started by a write keeps the line low for exactly PULSE cycles after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| rx_cfg | output | 8 | Receiver configuration word |
| adc_cfg | output | 8 | Converter configuration word |
| rx_rst_n | output | 1 | Receiver reset, active low |
| adc_rst_n | output | 1 | Converter reset, active low |

## Verification
The assertions check several relations on every cycle. A watched-field change must drive the matching reset line low on the next cycle. A released reset line implies its enable bit is set. A write must land in the register, and a same-value write on an idle line must not pull the line low. Inside the pulser, the counter must reload on a start and otherwise count down by one. The exact pulse length, the restart that extends a pulse, the reset values and the unmapped-address behaviour can only be shown by the bench scenarios. There, a behavioural model checks the outputs against the cycle counts on every clock.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
  localparam int DW = 8;

  // Convert a microsecond interval into a whole number of clock cycles (at least 1).
  function automatic int pulse_cycles(input longint clk_hz, input longint usec);
    longint c;
    c = (clk_hz * usec) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // True when any bit selected by mask differs between the stored and incoming word.
  function automatic logic watched_change(input logic [DW-1:0] cur,
                                          input logic [DW-1:0] nxt,
                                          input logic [DW-1:0] mask);
    return |((cur ^ nxt) & mask);
  endfunction
endpackage

// File: rtl/acfg_word.sv
module acfg_word
  import acfg_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL    = '0,
  parameter logic [DW-1:0] WATCH_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          fmt_change
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= wdata;
  end

  assign fmt_change = we & watched_change(q, wdata, WATCH_MASK);

  // R7: without a write the stored word holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/acfg_pulser.sv
module acfg_pulser #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= LOAD;
    else if (start) cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8: a start, even mid-pulse, reloads the full count
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == LOAD);
  // R9: an active pulse counts down by one per cycle
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/audio_cfg_bank.sv
module audio_cfg_bank
  import acfg_pkg::*;
#(
  parameter longint CLK_HZ   = 50_000_000,
  parameter int     PULSE_US = 300,
  parameter int     AW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    rx_cfg,
  output logic [7:0]    adc_cfg,
  output logic          rx_rst_n,
  output logic          adc_rst_n
);
  localparam int NDEV  = 2;
  localparam int PULSE = pulse_cycles(CLK_HZ, longint'(PULSE_US));
  localparam logic [NDEV-1:0][7:0] RSTV = {8'h41, 8'h38};
  localparam logic [NDEV-1:0][7:0] MASK = {8'h02, 8'h0E};
  localparam logic [NDEV-1:0][2:0] RBIT = {3'd0, 3'd4};

  logic [NDEV-1:0][7:0] word;
  logic [NDEV-1:0]      dev_busy;
  logic [NDEV-1:0]      dev_rst_n;
  logic [NDEV-1:0]      dev_change;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic sel;
    assign sel = wr_en && (addr == AW'(i));

    acfg_word #(.RST_VAL(RSTV[i]), .WATCH_MASK(MASK[i])) u_word (
      .clk(clk), .rst_n(rst_n), .we(sel), .wdata(wdata),
      .q(word[i]), .fmt_change(dev_change[i])
    );

    acfg_pulser #(.CYCLES(PULSE)) u_pulse (
      .clk(clk), .rst_n(rst_n), .start(dev_change[i]), .busy(dev_busy[i])
    );

    assign dev_rst_n[i] = word[i][RBIT[i]] & ~dev_busy[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NDEV; i++)
      if (addr == AW'(i)) rdata = word[i];
  end

  assign rx_cfg    = word[0];
  assign adc_cfg   = word[1];
  assign rx_rst_n  = dev_rst_n[0];
  assign adc_rst_n = dev_rst_n[1];

  logic rx_busy;
  assign rx_busy = dev_busy[0];

  // R3: a receiver format-field change drives its reset low next cycle
  p_rx_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(0) && ((wdata ^ rx_cfg) & 8'h0E) != 8'h00 |=> !rx_rst_n);
  // R4: a converter format change drives its reset low next cycle
  p_adc_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(1) && (wdata[1] != adc_cfg[1]) |=> !adc_rst_n);
  // R5: same-value write on an idle line leaves the line following its bit
  p_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(0) && wdata == rx_cfg && !rx_busy |=> rx_rst_n == rx_cfg[4]);
  // R6: a released line implies its enable bit is set
  p_rel_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_n |-> rx_cfg[4]);
  p_rel_adc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst_n |-> adc_cfg[0]);
  // R7: a write lands in the addressed word
  p_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(0) |=> rx_cfg == $past(wdata));
endmodule

// File: tb/audio_cfg_bank_test.sv
module audio_cfg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 30; // 100 kHz * 300 us

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, rx_cfg, adc_cfg;
  logic       rx_rst_n, adc_rst_n;

  int nvec = 0, nfail = 0;
  bit done = 0;

  audio_cfg_bank #(.CLK_HZ(100_000), .PULSE_US(300), .AW(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_cfg(rx_cfg), .adc_cfg(adc_cfg),
    .rx_rst_n(rx_rst_n), .adc_rst_n(adc_rst_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int   m_rx, m_adc, c_rx, c_adc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx = 'h38; m_adc = 'h41; c_rx = N; c_adc = N;
    end else begin
      bit t_rx, t_adc;
      t_rx = 0; t_adc = 0;
      if (wr_en && addr == 0) begin
        t_rx = ((m_rx >> 1) & 7) != ((wdata >> 1) & 7);
        m_rx = wdata;
      end
      if (wr_en && addr == 1) begin
        t_adc = ((m_adc >> 1) & 1) != ((wdata >> 1) & 1);
        m_adc = wdata;
      end
      c_rx  = t_rx  ? N : (c_rx  > 0 ? c_rx  - 1 : 0);
      c_adc = t_adc ? N : (c_adc > 0 ? c_adc - 1 : 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    int er;
    er = (addr == 0) ? m_rx : (addr == 1) ? m_adc : 0;
    chk("R7 rdata", rdata, er);
    chk("R7 rx_cfg", rx_cfg, m_rx);
    chk("R7 adc_cfg", adc_cfg, m_adc);
    chk("R6 rx_rst_n", rx_rst_n, ((m_rx >> 4) & 1) && c_rx == 0);
    chk("R6 adc_rst_n", adc_rst_n, (m_adc & 1) && c_adc == 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic pulse_len(string tag, bit rx);
    repeat (N-1) @(negedge clk);
    chk({tag, " still low"}, rx ? rx_rst_n : adc_rst_n, 0);
    @(negedge clk);
    chk({tag, " released"}, rx ? rx_rst_n : adc_rst_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 rx low in reset", rx_rst_n, 0);
    chk("R2 adc low in reset", adc_rst_n, 0);
    rst_n = 1;
    addr = 1; #1; chk("R1 adc reset value", rdata, 'h41);
    addr = 0; #1; chk("R1 rx reset value", rdata, 'h38);
    repeat (N-1) @(negedge clk);
    chk("R2 rx low at N-1", rx_rst_n, 0);
    chk("R2 adc low at N-1", adc_rst_n, 0);
    @(negedge clk);
    chk("R2 rx released at N", rx_rst_n, 1);
    chk("R2 adc released at N", adc_rst_n, 1);

    wr(0, 'h3A); chk("R3 rx pulse on format bit", rx_rst_n, 0);
    chk("R4 adc untouched by rx write", adc_rst_n, 1);
    pulse_len("R9 rx", 1);

    wr(0, 'h3A); chk("R5 same value no pulse", rx_rst_n, 1);
    repeat (3) @(negedge clk); chk("R5 still released", rx_rst_n, 1);

    wr(0, 'h2A); chk("R6 enable bit 0 holds reset", rx_rst_n, 0);
    wr(0, 'h3A); chk("R6 enable bit 1 releases at once", rx_rst_n, 1);

    wr(0, 'hFB); chk("R5 unwatched bits no pulse", rx_rst_n, 1);
    chk("R7 readback", rx_cfg, 'hFB);

    wr(0, 'hFF); chk("R3 ratio bit pulse", rx_rst_n, 0);
    pulse_len("R3 rx", 1);
    wr(0, 'hF7); chk("R3 master/slave bit pulse", rx_rst_n, 0);
    pulse_len("R3 rx ms", 1);

    wr(1, 'h43); chk("R4 adc pulse", adc_rst_n, 0);
    chk("R4 rx untouched", rx_rst_n, 1);
    pulse_len("R4 adc", 0);
    wr(1, 'h47); chk("R5 adc unwatched bit", adc_rst_n, 1);

    wr(0, 'hF3);
    repeat (9) @(negedge clk);
    wr(0, 'hF1);
    pulse_len("R8 restart", 1);

    wr(2, 'hFF);
    addr = 2; #1; chk("R7 unmapped reads zero", rdata, 0);
    chk("R7 unmapped write ignored rx", rx_cfg, 'hF1);
    chk("R7 unmapped write ignored adc", adc_cfg, 'h47);
    addr = 0;

    wr(1, 'h46); chk("R6 adc enable low", adc_rst_n, 0);
    wr(1, 'h47); chk("R6 adc enable high", adc_rst_n, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule